// File: doc/BRIEF.md
# Low-Side Channel Gate Controller with Fault Protection

This block produces the gate-enable signals for a bank of low-side output switches. Each cycle it combines the programmed on/off bits, a shared pulse-width input pin and the per-channel mixing settings into a demanded state. It then removes that demand wherever a protection condition applies, and registers the result onto the gate outputs.

Three protection mechanisms are applied. The first is a per-channel over-temperature shutdown, which either retries automatically or stays latched off. The second is a per-channel fast short-circuit shutdown, which acts on a drain-voltage-high flag that persists while the channel conducts, and which each channel can bypass. The third is a global over-voltage shutdown with a persistence filter. When over-voltage ends, the outputs either resume their programmed state or stay off. In the stay-off case a one-cycle request tells the surrounding register block to clear its on/off copy.

Latched shutdowns hold until the owning channel's on/off bit is written to 0, or until reset. The analog comparators and current limiting sit outside this block and deliver their flags synchronous to `clk`.

Top module: `lsd_gate_guard`

## Requirements
- R1: Channel i's demand is `on_bits[i]` when `pwm_en[i]`=0. When `pwm_en[i]`=1, the demand is `on_bits[i] & pwm_in` if `and_or[i]`=0, and `on_bits[i] | pwm_in` if `and_or[i]`=1. With no protection active, `gate` shows the demand one clock edge after the inputs are applied.
- R2: An active `ot_flag[i]` removes channel i from `gate` at the next edge. All other channels are unaffected.
- R3: With `therm_retry`=1, a channel turned off by over-temperature returns to its demand on the edge after `ot_flag[i]` clears.
- R4: With `therm_retry`=0, a channel that saw `ot_flag[i]` while `on_bits[i]`=1 stays off after the flag clears. It is released once `on_bits[i]` has been 0 for at least one cycle.
- R5: With `sfpd[i]`=0, if `vds_hi[i]` is high on SHORT_DLY consecutive edges while `gate[i]`=1, the channel latches off and `gate[i]` falls on the following edge. The latch is released only when `on_bits[i]` is 0 or on reset.
- R6: With `sfpd[i]`=1, `vds_hi[i]` has no effect on `gate[i]`.
- R7: If `ov_flag` is high on OV_DLY consecutive edges, `ov_shutdown` rises and all gates are 0 from the next edge on. A pulse shorter than OV_DLY edges changes nothing.
- R8: When `ov_flag` falls during a shutdown with `ov_resume`=1, `ov_shutdown` clears at the next edge and the gates return to their demand one edge later.
- R9: When `ov_flag` falls during a shutdown with `ov_resume`=0, `ov_clear_req` is 1 for exactly one cycle. Every channel then stays off until its `on_bits` bit has been 0.
- R10: Synchronous `rst` drives `gate`, `ov_shutdown` and `ov_clear_req` to 0 and clears all latched shutdowns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_bits | input | N_CH | Programmed on/off state per channel |
| pwm_en | input | N_CH | Channel follows pulse-width input when 1 |
| and_or | input | N_CH | 0: AND with pulse input, 1: OR |
| sfpd | input | N_CH | 1: bypass fast short shutdown |
| pwm_in | input | 1 | Shared pulse-width input, synchronised |
| therm_retry | input | 1 | 1: auto-retry after over-temperature |
| ov_resume | input | 1 | 1: resume after over-voltage |
| ot_flag | input | N_CH | Over-temperature flag per channel |
| vds_hi | input | N_CH | Drain-voltage-high flag per channel |
| ov_flag | input | 1 | Supply over-voltage flag |
| gate | output | N_CH | Registered gate enables |
| ov_shutdown | output | 1 | Global over-voltage shutdown active |
| ov_clear_req | output | 1 | One-cycle request to clear on/off copy |

## Verification
The assertions assume that every flag and control input is already synchronous to `clk` and changes only between edges. They also assume that the on/off copy is supplied from outside, so a clear request takes effect only when the driver of `on_bits` honours it. The stimulus meets these assumptions by changing every input on the falling clock edge. It plays the register-block role itself, writing the on/off bits to 0 and back after a clear request or a latched fault. Flag pulses are held for chosen counts relative to the two small delay parameters, so that each crosses a filter threshold or deliberately falls short of one.

// File: rtl/lsd_gate_pkg.sv
package lsd_gate_pkg;
  localparam int unsigned CH_DEFAULT = 16;
  localparam int unsigned SHORT_DLY_DEFAULT = 90000; // 450 us at 200 MHz
  localparam int unsigned OV_DLY_DEFAULT = 10000;     // 50 us at 200 MHz

  function automatic logic mix_demand(input logic on, input logic en,
                                      input logic ao, input logic pwm);
    if (!en) return on;
    return ao ? (on | pwm) : (on & pwm);
  endfunction
endpackage

// File: rtl/lsd_gate_mix.sv
module lsd_gate_mix
  import lsd_gate_pkg::*;
#(
  parameter int unsigned N_CH = CH_DEFAULT
) (
  input  logic [N_CH-1:0] on_bits,
  input  logic [N_CH-1:0] pwm_en,
  input  logic [N_CH-1:0] and_or,
  input  logic            pwm_in,
  output logic [N_CH-1:0] demand
);
  for (genvar i = 0; i < N_CH; i++) begin : g_mix
    always_comb demand[i] = mix_demand(on_bits[i], pwm_en[i], and_or[i], pwm_in);
  end
endmodule

// File: rtl/lsd_chan_guard.sv
module lsd_chan_guard
  import lsd_gate_pkg::*;
#(
  parameter int unsigned SHORT_DLY = SHORT_DLY_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic on_bit,
  input  logic gate_now,
  input  logic sfpd,
  input  logic therm_retry,
  input  logic ot_flag,
  input  logic vds_hi,
  output logic kill
);
  localparam int unsigned CW = (SHORT_DLY < 2) ? 1 : $clog2(SHORT_DLY);
  localparam logic [CW-1:0] LAST = CW'(SHORT_DLY - 1);

  logic [CW-1:0] cnt;
  logic          th_latch;
  logic          sh_latch;
  logic          armed;
  logic          hit;

  always_comb begin
    armed = gate_now & ~sfpd & vds_hi;
    hit   = armed & (cnt == LAST);
    kill  = ot_flag | th_latch | sh_latch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      th_latch <= 1'b0;
      sh_latch <= 1'b0;
    end else begin
      if (!armed)            cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;

      if (!on_bit)                          th_latch <= 1'b0;
      else if (ot_flag && !therm_retry)     th_latch <= 1'b1;

      if (!on_bit)   sh_latch <= 1'b0;
      else if (hit)  sh_latch <= 1'b1;
    end
  end
endmodule

// File: rtl/lsd_ov_guard.sv
module lsd_ov_guard
  import lsd_gate_pkg::*;
#(
  parameter int unsigned N_CH   = CH_DEFAULT,
  parameter int unsigned OV_DLY = OV_DLY_DEFAULT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ov_flag,
  input  logic            ov_resume,
  input  logic [N_CH-1:0] on_bits,
  output logic            shut,
  output logic            clear_req,
  output logic [N_CH-1:0] hold
);
  localparam int unsigned CW = (OV_DLY < 2) ? 1 : $clog2(OV_DLY);
  localparam logic [CW-1:0] LAST = CW'(OV_DLY - 1);

  logic [CW-1:0] cnt;
  logic          recover;

  always_comb recover = shut & ~ov_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      shut      <= 1'b0;
      clear_req <= 1'b0;
    end else begin
      if (!ov_flag)         cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;

      if (!ov_flag)                  shut <= 1'b0;
      else if (cnt == LAST)          shut <= 1'b1;

      clear_req <= recover & ~ov_resume;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst || !on_bits[i])            hold[i] <= 1'b0;
      else if (recover && !ov_resume)    hold[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/lsd_gate_guard.sv
module lsd_gate_guard
  import lsd_gate_pkg::*;
#(
  parameter int unsigned N_CH      = CH_DEFAULT,
  parameter int unsigned SHORT_DLY = SHORT_DLY_DEFAULT,
  parameter int unsigned OV_DLY    = OV_DLY_DEFAULT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] on_bits,
  input  logic [N_CH-1:0] pwm_en,
  input  logic [N_CH-1:0] and_or,
  input  logic [N_CH-1:0] sfpd,
  input  logic            pwm_in,
  input  logic            therm_retry,
  input  logic            ov_resume,
  input  logic [N_CH-1:0] ot_flag,
  input  logic [N_CH-1:0] vds_hi,
  input  logic            ov_flag,
  output logic [N_CH-1:0] gate,
  output logic            ov_shutdown,
  output logic            ov_clear_req
);
  logic [N_CH-1:0] demand;
  logic [N_CH-1:0] kill;
  logic [N_CH-1:0] hold;

  lsd_gate_mix #(.N_CH(N_CH)) u_mix (
    .on_bits(on_bits), .pwm_en(pwm_en), .and_or(and_or),
    .pwm_in(pwm_in), .demand(demand)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    lsd_chan_guard #(.SHORT_DLY(SHORT_DLY)) u_chan (
      .clk(clk), .rst(rst), .on_bit(on_bits[i]), .gate_now(gate[i]),
      .sfpd(sfpd[i]), .therm_retry(therm_retry), .ot_flag(ot_flag[i]),
      .vds_hi(vds_hi[i]), .kill(kill[i])
    );
  end

  lsd_ov_guard #(.N_CH(N_CH), .OV_DLY(OV_DLY)) u_ov (
    .clk(clk), .rst(rst), .ov_flag(ov_flag), .ov_resume(ov_resume),
    .on_bits(on_bits), .shut(ov_shutdown), .clear_req(ov_clear_req),
    .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) gate <= '0;
    else     gate <= demand & ~kill & ~hold & {N_CH{~ov_shutdown}};
  end
endmodule

// File: rtl/lsd_gate_guard_chk.sv
module lsd_gate_guard_chk #(
  parameter int unsigned N_CH = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] on_bits,
  input logic [N_CH-1:0] pwm_en,
  input logic [N_CH-1:0] and_or,
  input logic            pwm_in,
  input logic [N_CH-1:0] ot_flag,
  input logic [N_CH-1:0] gate,
  input logic            ov_shutdown,
  input logic            ov_clear_req
);
  AST_GATE_NEEDS_DEMAND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate & ~$past(on_bits | ({N_CH{pwm_in}} & pwm_en & and_or))) == '0)); // R1

  AST_HOT_CHANNEL_OFF: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate & $past(ot_flag)) == '0)); // R2

  AST_OV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (ov_shutdown && $past(ov_shutdown)) |-> (gate == '0)); // R7

  AST_CLEAR_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    ov_clear_req |=> !ov_clear_req); // R9

  AST_CLEAR_AFTER_SHUT: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_clear_req) |-> $past(ov_shutdown)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (gate == '0 && !ov_shutdown && !ov_clear_req)); // R10
endmodule

bind lsd_gate_guard lsd_gate_guard_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .on_bits(on_bits), .pwm_en(pwm_en), .and_or(and_or),
  .pwm_in(pwm_in), .ot_flag(ot_flag), .gate(gate),
  .ov_shutdown(ov_shutdown), .ov_clear_req(ov_clear_req)
);

// File: tb/lsd_gate_guard_test.sv
`timescale 1ns/1ps
module lsd_gate_guard_test;
  localparam int N = 16;
  localparam int SD = 8;
  localparam int OD = 6;
  localparam int NV = 6;
  // {on, pwm_en, and_or, pwm(16b field, bit0 used), expected}
  localparam logic [79:0] VEC [NV] = '{
    {16'hA5A5, 16'h0000, 16'h0000, 16'h0001, 16'hA5A5},
    {16'hA5A5, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    {16'hA5A5, 16'hFFFF, 16'h0000, 16'h0001, 16'hA5A5},
    {16'hA5A5, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFF},
    {16'h3C3C, 16'h00FF, 16'h0F0F, 16'h0000, 16'h3C0C},
    {16'h3C3C, 16'h00FF, 16'h0F0F, 16'h0001, 16'h3C3F}
  };

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] on_bits, pwm_en, and_or, sfpd, ot_flag, vds_hi;
  logic pwm_in, therm_retry, ov_resume, ov_flag;
  logic [N-1:0] gate;
  logic ov_shutdown, ov_clear_req;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lsd_gate_guard #(.N_CH(N), .SHORT_DLY(SD), .OV_DLY(OD)) uut (
    .clk(clk), .rst(rst), .on_bits(on_bits), .pwm_en(pwm_en), .and_or(and_or),
    .sfpd(sfpd), .pwm_in(pwm_in), .therm_retry(therm_retry),
    .ov_resume(ov_resume), .ot_flag(ot_flag), .vds_hi(vds_hi),
    .ov_flag(ov_flag), .gate(gate), .ov_shutdown(ov_shutdown),
    .ov_clear_req(ov_clear_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; on_bits = '0; pwm_en = '0; and_or = '0; sfpd = '0;
    pwm_in = 1'b0; therm_retry = 1'b1; ov_resume = 1'b1;
    ot_flag = '0; vds_hi = '0; ov_flag = 1'b0;
    edges(3);
    // R10 reset state
    chk("R10 gate", 32'(gate), 32'h0);
    chk("R10 ovsd", 32'(ov_shutdown), 32'h0);
    chk("R10 clr", 32'(ov_clear_req), 32'h0);
    rst = 1'b0;

    // R1 vector table
    for (int v = 0; v < NV; v++) begin
      on_bits = VEC[v][79:64]; pwm_en = VEC[v][63:48];
      and_or = VEC[v][47:32]; pwm_in = VEC[v][16];
      edges(1);
      chk("R1 mix", 32'(gate), 32'(VEC[v][15:0]));
    end

    pwm_en = '0; and_or = '0; on_bits = 16'hFFFF;
    edges(2);
    // R2 / R3 thermal auto-retry
    ot_flag = 16'h0008;
    edges(1);
    chk("R2 hot channel only", 32'(gate), 32'h0000FFF7);
    ot_flag = '0;
    edges(1);
    chk("R3 retry resumes", 32'(gate), 32'h0000FFFF);

    // R4 latched thermal
    therm_retry = 1'b0;
    ot_flag = 16'h0008;
    edges(1);
    ot_flag = '0;
    edges(4);
    chk("R4 stays off", 32'(gate), 32'h0000FFF7);
    on_bits = 16'hFFF7;
    edges(1);
    on_bits = 16'hFFFF;
    edges(1);
    chk("R4 released", 32'(gate), 32'h0000FFFF);
    therm_retry = 1'b1;

    // R5 short-fault latch
    vds_hi = 16'h0010;
    edges(SD - 1);
    chk("R5 before delay", 32'(gate), 32'h0000FFFF);
    edges(2);
    chk("R5 after delay", 32'(gate), 32'h0000FFEF);
    vds_hi = '0;
    edges(3);
    chk("R5 latched", 32'(gate), 32'h0000FFEF);
    on_bits = 16'hFFEF;
    edges(1);
    on_bits = 16'hFFFF;
    edges(1);
    chk("R5 released", 32'(gate), 32'h0000FFFF);

    // R6 bypass
    sfpd = 16'h0010;
    vds_hi = 16'h0010;
    edges(3 * SD);
    chk("R6 bypass", 32'(gate), 32'h0000FFFF);
    vds_hi = '0; sfpd = '0;

    // R7 short over-voltage pulse ignored
    ov_flag = 1'b1;
    edges(OD - 1);
    ov_flag = 1'b0;
    edges(2);
    chk("R7 glitch ignored", 32'(gate), 32'h0000FFFF);
    chk("R7 glitch no sd", 32'(ov_shutdown), 32'h0);
    ov_flag = 1'b1;
    edges(OD + 2);
    chk("R7 all off", 32'(gate), 32'h0);
    chk("R7 sd flag", 32'(ov_shutdown), 32'h1);

    // R8 resume
    ov_flag = 1'b0;
    edges(1);
    chk("R8 sd cleared", 32'(ov_shutdown), 32'h0);
    edges(1);
    chk("R8 resumed", 32'(gate), 32'h0000FFFF);
    chk("R8 no clear req", 32'(ov_clear_req), 32'h0);

    // R9 stay off
    ov_resume = 1'b0;
    ov_flag = 1'b1;
    edges(OD + 2);
    ov_flag = 1'b0;
    edges(1);
    chk("R9 clear req", 32'(ov_clear_req), 32'h1);
    edges(1);
    chk("R9 req pulse", 32'(ov_clear_req), 32'h0);
    edges(2);
    chk("R9 stay off", 32'(gate), 32'h0);
    on_bits = '0;
    edges(1);
    on_bits = 16'h00FF;
    edges(1);
    chk("R9 reprogram", 32'(gate), 32'h000000FF);
    ov_resume = 1'b1;

    // R10 reset releases latched short
    on_bits = 16'hFFFF;
    vds_hi = 16'h0001;
    edges(SD + 3);
    vds_hi = '0;
    chk("R10 pre latched", 32'(gate), 32'h0000FFFE);
    rst = 1'b1;
    edges(1);
    chk("R10 reset gate", 32'(gate), 32'h0);
    rst = 1'b0;
    edges(1);
    chk("R10 latch cleared", 32'(gate), 32'h0000FFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule